// File: doc/BRIEF.md
# Card Presence Detector with Interrupt

This block watches the presence switches of two smart-card slots, called slot A and slot B. Each raw switch line is brought into the clock domain. A digital filter then removes contact bounce. The filter is timed by a slow tick, which the block makes itself from the system clock with a divider, so that one tick equals one millisecond. A level change is accepted only after it has stayed unbroken for the whole filter window.

Each slot has its own switch polarity, either normally open or normally closed. The host writes the polarity through an address-decoded write on the chip-select, program and address pins. The written value waits in a staging register and becomes active only on the next rising edge of the program strobe. Every accepted insertion or removal pulls the shared active-low interrupt. The host clears it either by raising chip select or by requesting power-on for that slot while chip select is low. An accepted removal also sends a one-cycle request to the power sequencer of that slot, whatever the power-on pin is doing.

All pins are plain control and status lines. No data stream passes through the block, so it has no valid/ready handshake and no back-pressure.

Top module: `card_presence_ctl`

## Requirements
- R1: After reset the interrupt is high (inactive), both slots use normally-open polarity, both filters are idle with the accepted line level at 1, so both present bits read 0, and no removal request is active.
- R2: A change on a synchronised detect line is accepted only after it has stayed unbroken for more than FILT_TICKS tick periods and at most FILT_TICKS+1 tick periods. A change that reverts before that restarts the filter and has no effect on status or interrupt.
- R3: A polarity write happens when cs=0, prog=0, addr[3]=1, addr[2]=1 and addr[1]=0. addr[0]=0 selects normally open and addr[0]=1 selects normally closed. card_sel=1 writes slot A, card_sel=0 writes slot B, and the other slot keeps its value.
- R4: A written polarity becomes active only on the next rising edge of prog. Writes attempted with cs=1 or prog=1 leave the stored polarity unchanged.
- R5: present[0] belongs to slot A and present[1] to slot B. For a normally-open slot, present is 1 when the accepted line is 0. For a normally-closed slot, present is 1 when the accepted line is 1.
- R6: irq_n goes low in the cycle after a filtered insertion or a filtered removal is accepted on either slot. A change of polarity alone does not assert it.
- R7: A rising edge on cs clears all pending interrupt causes, so irq_n returns high unless a new event is accepted in the same cycle.
- R8: pwr_on=1 with cs=0 clears only the pending cause of the slot picked by card_sel (1 = A, 0 = B). irq_n stays low while the other slot still has a pending cause.
- R9: A filtered removal gives a single-cycle pulse on rm_req for that slot (bit 0 = A, bit 1 = B). The pulse appears for any value of pwr_on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| det_raw | input | 2 | Raw presence switch lines, bit 0 slot A, bit 1 slot B |
| cs | input | 1 | Chip select, active low |
| prog | input | 1 | Program strobe; its rising edge applies staged polarities |
| addr | input | 4 | Host address bits used to decode the polarity write |
| card_sel | input | 1 | Slot select: 1 = slot A, 0 = slot B |
| pwr_on | input | 1 | Power-on request, also used as an interrupt clear |
| irq_n | output | 1 | Active-low interrupt |
| present | output | 2 | Filtered card-present status per slot |
| rm_req | output | 2 | One-cycle removal request per slot to the power sequencer |

## Verification
The embedded assertions check several things on every cycle. The accepted filter level changes only on a tick with the counter at its limit. Each removal request lasts exactly one cycle. Every accepted event drives the interrupt low on the next cycle. A chip-select rising edge or a matching power-on clear releases the pending cause. Outside a write, the staging register does not move, and outside a prog rising edge, the active polarity does not move. Other properties are shown only by the bench scenarios: the real length of the filter window measured from a pin change, rejection of a short glitch, presence under each polarity, slot selection of writes, and the ignored write attempts.

// File: rtl/cdet_pkg.sv
package cdet_pkg;
  localparam int NSLOT  = 2;
  localparam int SLOT_A = 0;
  localparam int SLOT_B = 1;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    POL_OPEN   = 1'b0,
    POL_CLOSED = 1'b1
  } sw_pol_e;

  // slot index picked by the host select pin (1 selects slot A)
  function automatic int unsigned sel_to_slot(input logic sel);
    return sel ? SLOT_A : SLOT_B;
  endfunction
endpackage

// File: rtl/cdet_tick.sv
module cdet_tick #(
  parameter int TICK_DIV = 100_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_q == LAST) begin
      div_q <= '0;
    end else begin
      div_q <= div_q + 1'b1;
    end
  end

  assign tick = (div_q == LAST);
endmodule

// File: rtl/cdet_filter.sv
module cdet_filter #(
  parameter int FILT_TICKS  = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic raw,
  output logic lvl,
  output logic commit
);
  localparam int CNT_W = $clog2(FILT_TICKS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FILT_TICKS);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   raw_s;
  logic                   lvl_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   differs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q <= '1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end
  end

  assign raw_s   = sync_q[SYNC_STAGES-1];
  assign differs = (raw_s != lvl_q);
  assign commit  = differs && tick && (cnt_q == CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lvl_q <= 1'b1;
      cnt_q <= '0;
    end else if (!differs) begin
      cnt_q <= '0;
    end else if (commit) begin
      lvl_q <= raw_s;
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign lvl = lvl_q;

  // R2: the accepted level moves only on a tick with the window fully counted
  p_lvl_after_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lvl_q) |-> ($past(cnt_q) == CNT_MAX && $past(tick)));

  // R2: a reverted line leaves the counter idle
  p_cnt_idle_on_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_s == lvl_q) |=> (cnt_q == '0));
endmodule

// File: rtl/cdet_polarity.sv
module cdet_polarity
  import cdet_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs,
  input  logic             prog,
  input  logic [3:0]       addr,
  input  logic             card_sel,
  output logic [NSLOT-1:0] pol_act
);
  logic [NSLOT-1:0] pol_stage_q;
  logic [NSLOT-1:0] pol_act_q;
  logic             prog_q;
  logic             wr_en;
  logic             prog_rise;
  sw_pol_e          wr_val;

  assign wr_en     = !cs && !prog && addr[3] && addr[2] && !addr[1];
  assign wr_val    = addr[0] ? POL_CLOSED : POL_OPEN;
  assign prog_rise = prog && !prog_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q <= 1'b1;
    end else begin
      prog_q <= prog;
    end
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic sel_hit;
    assign sel_hit = (sel_to_slot(card_sel) == s);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pol_stage_q[s] <= POL_OPEN;
        pol_act_q[s]   <= POL_OPEN;
      end else begin
        if (wr_en && sel_hit) begin
          pol_stage_q[s] <= wr_val;
        end
        if (prog_rise) begin
          pol_act_q[s] <= pol_stage_q[s];
        end
      end
    end
  end

  assign pol_act = pol_act_q;

  // R4: the active polarity moves only on a prog rising edge
  p_act_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !prog_rise |=> $stable(pol_act_q));

  // R3/R4: the staged polarity moves only on a decoded write
  p_stage_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(pol_stage_q));

  // R3: slot A takes addr[0] when card_sel is 1
  p_stage_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && card_sel) |=> (pol_stage_q[SLOT_A] == $past(addr[0])
                             && $stable(pol_stage_q[SLOT_B])));

  // R3: slot B takes addr[0] when card_sel is 0
  p_stage_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !card_sel) |=> (pol_stage_q[SLOT_B] == $past(addr[0])
                              && $stable(pol_stage_q[SLOT_A])));
endmodule

// File: rtl/cdet_irq.sv
module cdet_irq
  import cdet_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSLOT-1:0] evt,
  input  logic             cs,
  input  logic             pwr_on,
  input  logic             card_sel,
  output logic             irq_n
);
  logic [NSLOT-1:0] pend_q;
  logic [NSLOT-1:0] clr;
  logic             cs_q;
  logic             cs_rise;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
    end else begin
      cs_q <= cs;
    end
  end

  assign cs_rise = cs && !cs_q;

  for (genvar s = 0; s < NSLOT; s++) begin : g_src
    assign clr[s] = cs_rise || (pwr_on && !cs && (sel_to_slot(card_sel) == s));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pend_q[s] <= 1'b0;
      end else if (evt[s]) begin
        pend_q[s] <= 1'b1;
      end else if (clr[s]) begin
        pend_q[s] <= 1'b0;
      end
    end
  end

  assign irq_n = ~|pend_q;

  // R6: any accepted event drives the interrupt low on the next cycle
  p_evt_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> !irq_n);

  // R7: a chip-select rising edge with no new event releases the interrupt
  p_cs_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cs) && evt == '0) |=> irq_n);

  // R8: power-on with cs low clears slot A's cause when it is selected
  p_pwr_clear_a_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && !cs && card_sel && !evt[SLOT_A]) |=> !pend_q[SLOT_A]);

  // R8: power-on with cs low clears slot B's cause when it is selected
  p_pwr_clear_b_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_on && !cs && !card_sel && !evt[SLOT_B]) |=> !pend_q[SLOT_B]);
endmodule

// File: rtl/card_presence_ctl.sv
module card_presence_ctl
  import cdet_pkg::*;
#(
  parameter int TICK_DIV   = 100_000,
  parameter int FILT_TICKS = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] det_raw,
  input  logic       cs,
  input  logic       prog,
  input  logic [3:0] addr,
  input  logic       card_sel,
  input  logic       pwr_on,
  output logic       irq_n,
  output logic [1:0] present,
  output logic [1:0] rm_req
);
  logic             tick;
  logic [NSLOT-1:0] lvl;
  logic [NSLOT-1:0] commit;
  logic [NSLOT-1:0] pol_act;
  logic [NSLOT-1:0] rm_next;
  logic [NSLOT-1:0] rm_q;

  cdet_tick #(.TICK_DIV(TICK_DIV)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (tick)
  );

  cdet_polarity u_pol (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs       (cs),
    .prog     (prog),
    .addr     (addr),
    .card_sel (card_sel),
    .pol_act  (pol_act)
  );

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    logic new_present;

    cdet_filter #(
      .FILT_TICKS  (FILT_TICKS),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .raw    (det_raw[s]),
      .lvl    (lvl[s]),
      .commit (commit[s])
    );

    // presence decode: open switch reads low with a card, closed reads high
    assign present[s] = (pol_act[s] == POL_CLOSED) ? lvl[s] : ~lvl[s];

    // on a commit the accepted level flips, so judge the level being taken
    assign new_present = (pol_act[s] == POL_CLOSED) ? ~lvl[s] : lvl[s];
    assign rm_next[s]  = commit[s] && !new_present;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        rm_q[s] <= 1'b0;
      end else begin
        rm_q[s] <= rm_next[s];
      end
    end

    // R9: a removal request never lasts longer than one cycle
    p_rm_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rm_q[s] |=> !rm_q[s]);

    // R9: a removal request follows an accepted filter change
    p_rm_from_commit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rm_q[s] |-> $past(commit[s]));
  end

  assign rm_req = rm_q;

  cdet_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .evt      (commit),
    .cs       (cs),
    .pwr_on   (pwr_on),
    .card_sel (card_sel),
    .irq_n    (irq_n)
  );
endmodule

// File: tb/tb_card_presence_ctl.sv
module tb_card_presence_ctl;
  localparam int TB_DIV  = 4;
  localparam int TB_FILT = 50;
  localparam int EARLY   = 190;
  localparam int LATE    = 220;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] det_raw;
  logic       cs, prog, card_sel, pwr_on;
  logic [3:0] addr;
  logic       irq_n;
  logic [1:0] present, rm_req;

  int n_chk = 0;
  int n_bad = 0;
  int rmc_a = 0;
  int rmc_b = 0;
  int rm_wide = 0;
  logic [1:0] rm_prev = 2'b00;
  logic done = 1'b0;

  always #5 clk = ~clk;

  card_presence_ctl #(.TICK_DIV(TB_DIV), .FILT_TICKS(TB_FILT)) dut (
    .clk(clk), .rst_n(rst_n), .det_raw(det_raw), .cs(cs), .prog(prog),
    .addr(addr), .card_sel(card_sel), .pwr_on(pwr_on),
    .irq_n(irq_n), .present(present), .rm_req(rm_req)
  );

  always @(posedge clk) begin
    if (rst_n) begin
      if (rm_req[0]) rmc_a++;
      if (rm_req[1]) rmc_b++;
      if (rm_req[0] && rm_prev[0]) rm_wide++;
      if (rm_req[1] && rm_prev[1]) rm_wide++;
      rm_prev <= rm_req;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_pulse();
    @(negedge clk) cs = 1'b0;
    @(negedge clk) cs = 1'b1;
    wait_cyc(2);
  endtask

  task automatic prog_pulse();
    @(negedge clk) prog = 1'b1;
    @(negedge clk) prog = 1'b0;
    wait_cyc(2);
  endtask

  task automatic write_pol(input logic sel, input logic nc);
    @(negedge clk) begin
      cs = 1'b0; prog = 1'b0; addr = {3'b110, nc}; card_sel = sel;
    end
    @(negedge clk) begin
      cs = 1'b1; addr = 4'h0;
    end
    wait_cyc(2);
  endtask

  task automatic t_reset();
    chk("R1", "irq_n", irq_n, 1'b1);
    chk("R1", "present", present, 2'b00);
    chk("R1", "rm_req", rm_req, 2'b00);
  endtask

  task automatic t_insert_a();
    int base = rmc_a;
    @(negedge clk) det_raw[0] = 1'b0;
    wait_cyc(EARLY);
    chk("R2", "A present before window", present[0], 1'b0);
    chk("R2", "irq before window", irq_n, 1'b1);
    wait_cyc(LATE - EARLY);
    chk("R5", "A present after insert", present[0], 1'b1);
    chk("R6", "irq on insert", irq_n, 1'b0);
    chk("R9", "no removal on insert", rmc_a - base, 0);
  endtask

  task automatic t_cs_clear();
    cs_pulse();
    chk("R7", "irq after cs rise", irq_n, 1'b1);
    chk("R7", "A present kept", present[0], 1'b1);
  endtask

  task automatic t_glitch_b();
    @(negedge clk) det_raw[1] = 1'b0;
    wait_cyc(100);
    @(negedge clk) det_raw[1] = 1'b1;
    wait_cyc(300);
    chk("R2", "B after glitch", present[1], 1'b0);
    chk("R2", "irq after glitch", irq_n, 1'b1);
  endtask

  task automatic t_remove_a();
    int base = rmc_a;
    @(negedge clk) det_raw[0] = 1'b1;
    wait_cyc(LATE);
    chk("R5", "A present after removal", present[0], 1'b0);
    chk("R6", "irq on removal", irq_n, 1'b0);
    chk("R9", "A removal pulses", rmc_a - base, 1);
    chk("R9", "removal pulse width", rm_wide, 0);
  endtask

  task automatic t_pwr_clear();
    @(negedge clk) begin cs = 1'b0; card_sel = 1'b0; pwr_on = 1'b1; end
    @(negedge clk) pwr_on = 1'b0;
    wait_cyc(1);
    chk("R8", "irq kept, B selected", irq_n, 1'b0);
    @(negedge clk) begin card_sel = 1'b1; pwr_on = 1'b1; end
    @(negedge clk) pwr_on = 1'b0;
    wait_cyc(1);
    chk("R8", "irq cleared, A selected", irq_n, 1'b1);
    @(negedge clk) cs = 1'b1;
    wait_cyc(2);
  endtask

  task automatic t_b_select_and_pwr();
    int base;
    @(negedge clk) det_raw[1] = 1'b0;
    wait_cyc(LATE);
    chk("R5", "B present", present[1], 1'b1);
    @(negedge clk) begin cs = 1'b0; card_sel = 1'b1; pwr_on = 1'b1; end
    @(negedge clk) pwr_on = 1'b0;
    wait_cyc(1);
    chk("R8", "A clear leaves B cause", irq_n, 1'b0);
    @(negedge clk) begin card_sel = 1'b0; pwr_on = 1'b1; end
    @(negedge clk) pwr_on = 1'b0;
    wait_cyc(1);
    chk("R8", "B clear releases irq", irq_n, 1'b1);
    @(negedge clk) cs = 1'b1;
    base = rmc_b;
    @(negedge clk) begin pwr_on = 1'b1; det_raw[1] = 1'b1; end
    wait_cyc(LATE);
    chk("R9", "B removal with pwr_on high", rmc_b - base, 1);
    chk("R5", "B absent", present[1], 1'b0);
    chk("R6", "irq on B removal", irq_n, 1'b0);
    @(negedge clk) pwr_on = 1'b0;
    cs_pulse();
  endtask

  task automatic t_pol_staged();
    write_pol(1'b1, 1'b1);
    chk("R4", "A unchanged before prog edge", present[0], 1'b0);
    prog_pulse();
    chk("R3", "A closed polarity active", present[0], 1'b1);
    chk("R3", "B keeps open polarity", present[1], 1'b0);
    chk("R6", "no irq on polarity change", irq_n, 1'b1);
  endtask

  task automatic t_pol_ignored();
    @(negedge clk) begin cs = 1'b1; addr = 4'b1100; card_sel = 1'b1; end
    @(negedge clk) addr = 4'h0;
    prog_pulse();
    chk("R4", "write with cs high ignored", present[0], 1'b1);
    @(negedge clk) prog = 1'b1;
    @(negedge clk) begin cs = 1'b0; addr = 4'b1100; card_sel = 1'b1; end
    @(negedge clk) begin cs = 1'b1; addr = 4'h0; prog = 1'b0; end
    prog_pulse();
    chk("R4", "write with prog high ignored", present[0], 1'b1);
    @(negedge clk) begin cs = 1'b0; addr = 4'b1110; card_sel = 1'b1; end
    @(negedge clk) begin cs = 1'b1; addr = 4'h0; end
    prog_pulse();
    chk("R3", "addr[1]=1 ignored", present[0], 1'b1);
  endtask

  task automatic t_pol_b();
    write_pol(1'b0, 1'b1);
    prog_pulse();
    chk("R3", "B closed polarity active", present[1], 1'b1);
    chk("R3", "A keeps closed polarity", present[0], 1'b1);
    cs_pulse();
  endtask

  task automatic t_closed_remove_a();
    int base = rmc_a;
    @(negedge clk) det_raw[0] = 1'b0;
    wait_cyc(LATE);
    chk("R5", "closed A removed", present[0], 1'b0);
    chk("R9", "closed A removal pulse", rmc_a - base, 1);
    chk("R6", "irq on closed removal", irq_n, 1'b0);
    cs_pulse();
    chk("R7", "irq after second cs rise", irq_n, 1'b1);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; det_raw = 2'b11; cs = 1'b1; prog = 1'b0;
    addr = 4'h0; card_sel = 1'b1; pwr_on = 1'b0;
    wait_cyc(5);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(2);
    t_reset();
    t_insert_a();
    t_cs_clear();
    t_glitch_b();
    t_remove_a();
    t_pwr_clear();
    t_b_select_and_pwr();
    t_pol_staged();
    t_pol_ignored();
    t_pol_b();
    t_closed_remove_a();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule